// File: doc/BRIEF.md
# Configurable-Latency Memory Port Wrapper

This block wraps a storage array whose read is combinational and whose write takes effect at the next clock edge, and it presents ports with a chosen read latency and a chosen write latency. It builds the latency by delaying requests on their way into the array, not by registering data on the way out. The read address therefore travels through a short chain of registers and reaches the array just as the data is due. Write requests travel through a plain chain of registers and reach the array's one-cycle write at the right edge.

Three kinds of port are offered, each in a parameterised count. A read-only port takes an enable and an address. A write-only port takes an enable, address, data and a per-lane mask. A combined port takes an enable, a write-mode bit, an address, data and a mask. Inside the block each combined port becomes one read path and one write path, and the write-mode bit picks which of the two an enabled request goes to. The pipeline registers have no reset, so the user keeps every enable low until the pipelines have filled.

Top module: `lat_mem_wrap`

## Requirements
- R1: A read request (`rd_en`=1 with `rd_addr`=A) made in cycle c makes `rd_data` equal the array word at A during cycle c+RD_LAT.
- R2: Between read arrivals, `rd_data` keeps showing the word at the last address that arrived, and a write to that address shows up in `rd_data` as soon as the write takes effect.
- R3: A write request made in cycle c updates the array at the clock edge that ends cycle c+WR_LAT-1. Reads see the new data from cycle c+WR_LAT onward.
- R4: The data word is split into LANES lanes: lane i is bits [i*DATA_W/LANES +: DATA_W/LANES] and is guarded by mask bit i. A write changes only the lanes whose mask bit is 1, and a write with an all-zero mask changes nothing.
- R5: On a combined port, an enabled request with `rw_wmode`=1 is a write with the timing of R3. With `rw_wmode`=0 it is a read whose result appears on `rw_rdata` with the timing of R1.
- R6: A combined-port write, or an idle cycle, does not move the address that `rw_rdata` reads from. `rw_rdata` goes on showing the word at the last address read on that port.
- R7: A request with its enable low changes no array word and no read address, whatever its other inputs are.
- R8: When several writes to the same word take effect at the same edge, the port later in order wins for the lanes it writes. Write-only ports come first in index order, then combined ports in index order.
- R9: Every RD_LAT >= 1 and WR_LAT >= 1 is supported. With WR_LAT=1 the write request goes to the array with no added register, and with RD_LAT=1 the read enable is not delayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all pipeline registers and the array |
| rd_en | input | N_RD | Read request, one bit per read-only port |
| rd_addr | input | N_RD*AW | Read address per read-only port |
| rd_data | output | N_RD*DATA_W | Read data per read-only port |
| wr_en | input | N_WR | Write request per write-only port |
| wr_addr | input | N_WR*AW | Write address per write-only port |
| wr_data | input | N_WR*DATA_W | Write data per write-only port |
| wr_mask | input | N_WR*LANES | Lane mask per write-only port |
| rw_en | input | N_RW | Request per combined port |
| rw_wmode | input | N_RW | 1 = write, 0 = read, per combined port |
| rw_addr | input | N_RW*AW | Address per combined port |
| rw_wdata | input | N_RW*DATA_W | Write data per combined port |
| rw_wmask | input | N_RW*LANES | Lane mask per combined port |
| rw_rdata | output | N_RW*DATA_W | Read data per combined port |

## Verification
A wrong stage in a read-address chain shows at the ports in the cycle a read should arrive. `rd_data` or `rw_rdata` then holds the word of a neighbouring or stale request, and it goes on holding it until the next read arrives. A fault in a write chain stays hidden until the affected word is read back. At the earliest that is WR_LAT cycles after the request, so the bench reads every word it writes shortly after each write, and it compares the read data port against a model in every cycle once a read has arrived. The latency pairs exercised (2/3, 1/1, 3/1) put the zero-stage and multi-stage variants side by side.

// File: rtl/lmw_pkg.sv
package lmw_pkg;
  // Address width for a given depth, never below one bit.
  function automatic int unsigned width_of(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Lane that owns a given data bit.
  function automatic int unsigned lane_of(int unsigned bit_idx, int unsigned lane_w);
    return bit_idx / lane_w;
  endfunction

  // Registers in front of the array for a given latency (array adds one write cycle).
  function automatic int unsigned pre_stages(int unsigned lat);
    return (lat == 0) ? 0 : lat - 1;
  endfunction
endpackage

// File: rtl/lmw_shift.sv
module lmw_shift #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 0
) (
  input  logic                     clk,
  input  logic [W-1:0]             d,
  output logic [STAGES:0][W-1:0]   taps
);
  assign taps[0] = d;
  generate
    if (STAGES > 0) begin : g_regs
      logic [W-1:0] st [STAGES];
      always_ff @(posedge clk) begin
        st[0] <= d;
        for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
      end
      for (genvar k = 1; k <= STAGES; k++) begin : g_tap
        assign taps[k] = st[k-1];
      end
    end
  endgenerate
endmodule

// File: rtl/lmw_rd_path.sv
module lmw_rd_path #(
  parameter int unsigned AW  = 4,
  parameter int unsigned LAT = 1
) (
  input  logic          clk,
  input  logic          req,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] arr_addr,
  output logic          tail_ld
);
  localparam int unsigned EN_ST = lmw_pkg::pre_stages(LAT);

  logic [EN_ST:0][0:0] en_tap;
  lmw_shift #(.W(1), .STAGES(EN_ST)) u_en (.clk(clk), .d(req), .taps(en_tap));

  // Stage k loads only when the request sitting at depth k is valid (R1, R7).
  logic [AW-1:0] a_st [LAT];
  always_ff @(posedge clk) begin
    if (en_tap[0][0]) a_st[0] <= addr;
    for (int k = 1; k < LAT; k++)
      if (en_tap[k][0]) a_st[k] <= a_st[k-1];
  end

  assign arr_addr = a_st[LAT-1];
  assign tail_ld  = en_tap[EN_ST][0];
endmodule

// File: rtl/lmw_wr_path.sv
module lmw_wr_path #(
  parameter int unsigned AW    = 4,
  parameter int unsigned DW    = 16,
  parameter int unsigned LANES = 2,
  parameter int unsigned LAT   = 1
) (
  input  logic             clk,
  input  logic             req,
  input  logic [LANES-1:0] mask,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    data,
  output logic             arr_we,
  output logic [LANES-1:0] arr_mask,
  output logic [AW-1:0]    arr_addr,
  output logic [DW-1:0]    arr_data
);
  localparam int unsigned PW = 1 + LANES + AW + DW;
  localparam int unsigned ST = lmw_pkg::pre_stages(LAT);

  logic [ST:0][PW-1:0] taps;
  lmw_shift #(.W(PW), .STAGES(ST)) u_bundle (
    .clk(clk), .d({req, mask, addr, data}), .taps(taps)
  );
  assign {arr_we, arr_mask, arr_addr, arr_data} = taps[ST];
endmodule

// File: rtl/lmw_array.sv
module lmw_array #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 16,
  parameter int unsigned LANES = 2,
  parameter int unsigned NR    = 2,
  parameter int unsigned NW    = 2
) (
  input  logic                       clk,
  input  logic [NR*lmw_pkg::width_of(DEPTH)-1:0] raddr,
  output logic [NR*DW-1:0]           rdata,
  input  logic [NW-1:0]              we,
  input  logic [NW*LANES-1:0]        wmask,
  input  logic [NW*lmw_pkg::width_of(DEPTH)-1:0] waddr,
  input  logic [NW*DW-1:0]           wdata
);
  localparam int unsigned AW = lmw_pkg::width_of(DEPTH);
  localparam int unsigned LW = DW / LANES;

  logic [DW-1:0] mem [DEPTH];

  // Later ports overwrite earlier ones at the same edge (R8); masked lanes only (R4).
  always_ff @(posedge clk) begin
    for (int p = 0; p < NW; p++)
      for (int b = 0; b < DW; b++)
        if (we[p] && wmask[p*LANES + lmw_pkg::lane_of(b, LW)])
          mem[waddr[p*AW +: AW]][b] <= wdata[p*DW + b];
  end

  generate
    for (genvar r = 0; r < NR; r++) begin : g_rd
      assign rdata[r*DW +: DW] = mem[raddr[r*AW +: AW]];
    end
  endgenerate
endmodule

// File: rtl/lat_mem_wrap.sv
module lat_mem_wrap #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = 2,
  parameter int unsigned RD_LAT = 2,
  parameter int unsigned WR_LAT = 2,
  parameter int unsigned N_RD   = 1,
  parameter int unsigned N_WR   = 1,
  parameter int unsigned N_RW   = 1
) (
  input  logic                                           clk,
  input  logic [N_RD-1:0]                                rd_en,
  input  logic [N_RD*lmw_pkg::width_of(DEPTH)-1:0]       rd_addr,
  output logic [N_RD*DATA_W-1:0]                         rd_data,
  input  logic [N_WR-1:0]                                wr_en,
  input  logic [N_WR*lmw_pkg::width_of(DEPTH)-1:0]       wr_addr,
  input  logic [N_WR*DATA_W-1:0]                         wr_data,
  input  logic [N_WR*LANES-1:0]                          wr_mask,
  input  logic [N_RW-1:0]                                rw_en,
  input  logic [N_RW-1:0]                                rw_wmode,
  input  logic [N_RW*lmw_pkg::width_of(DEPTH)-1:0]       rw_addr,
  input  logic [N_RW*DATA_W-1:0]                         rw_wdata,
  input  logic [N_RW*LANES-1:0]                          rw_wmask,
  output logic [N_RW*DATA_W-1:0]                         rw_rdata
);
  localparam int unsigned AW = lmw_pkg::width_of(DEPTH);
  localparam int unsigned NR = N_RD + N_RW;
  localparam int unsigned NW = N_WR + N_RW;

  generate
    if (RD_LAT < 1 || WR_LAT < 1 || LANES < 1 || (DATA_W % LANES) != 0 ||
        N_RD < 1 || N_WR < 1 || N_RW < 1) begin : g_bad_cfg
      $error("lat_mem_wrap: latencies must be >= 1 and DATA_W a multiple of LANES");
    end
  endgenerate

  // Named internal events, observed by the bound checker.
  logic [NR*AW-1:0]    arr_raddr;
  logic [NR-1:0]       rd_tail_ld;
  logic [NR*DATA_W-1:0] arr_rdata;
  logic [NW-1:0]       arr_we;
  logic [NW*LANES-1:0] arr_wmask;
  logic [NW*AW-1:0]    arr_waddr;
  logic [NW*DATA_W-1:0] arr_wdata;

  generate
    for (genvar r = 0; r < N_RD; r++) begin : g_rd
      lmw_rd_path #(.AW(AW), .LAT(RD_LAT)) u_rd (
        .clk(clk), .req(rd_en[r]), .addr(rd_addr[r*AW +: AW]),
        .arr_addr(arr_raddr[r*AW +: AW]), .tail_ld(rd_tail_ld[r])
      );
      assign rd_data[r*DATA_W +: DATA_W] = arr_rdata[r*DATA_W +: DATA_W];
    end

    for (genvar w = 0; w < N_WR; w++) begin : g_wr
      lmw_wr_path #(.AW(AW), .DW(DATA_W), .LANES(LANES), .LAT(WR_LAT)) u_wr (
        .clk(clk), .req(wr_en[w]), .mask(wr_mask[w*LANES +: LANES]),
        .addr(wr_addr[w*AW +: AW]), .data(wr_data[w*DATA_W +: DATA_W]),
        .arr_we(arr_we[w]), .arr_mask(arr_wmask[w*LANES +: LANES]),
        .arr_addr(arr_waddr[w*AW +: AW]), .arr_data(arr_wdata[w*DATA_W +: DATA_W])
      );
    end

    // Each combined port splits into a read path and a write path (R5, R6).
    for (genvar k = 0; k < N_RW; k++) begin : g_rw
      localparam int unsigned RS = N_RD + k;
      localparam int unsigned WS = N_WR + k;
      logic rd_req, wr_req;
      assign rd_req = rw_en[k] & ~rw_wmode[k];
      assign wr_req = rw_en[k] &  rw_wmode[k];

      lmw_rd_path #(.AW(AW), .LAT(RD_LAT)) u_rd (
        .clk(clk), .req(rd_req), .addr(rw_addr[k*AW +: AW]),
        .arr_addr(arr_raddr[RS*AW +: AW]), .tail_ld(rd_tail_ld[RS])
      );
      lmw_wr_path #(.AW(AW), .DW(DATA_W), .LANES(LANES), .LAT(WR_LAT)) u_wr (
        .clk(clk), .req(wr_req), .mask(rw_wmask[k*LANES +: LANES]),
        .addr(rw_addr[k*AW +: AW]), .data(rw_wdata[k*DATA_W +: DATA_W]),
        .arr_we(arr_we[WS]), .arr_mask(arr_wmask[WS*LANES +: LANES]),
        .arr_addr(arr_waddr[WS*AW +: AW]), .arr_data(arr_wdata[WS*DATA_W +: DATA_W])
      );
      assign rw_rdata[k*DATA_W +: DATA_W] = arr_rdata[RS*DATA_W +: DATA_W];
    end
  endgenerate

  lmw_array #(.DEPTH(DEPTH), .DW(DATA_W), .LANES(LANES), .NR(NR), .NW(NW)) u_array (
    .clk(clk), .raddr(arr_raddr), .rdata(arr_rdata),
    .we(arr_we), .wmask(arr_wmask), .waddr(arr_waddr), .wdata(arr_wdata)
  );
endmodule

// File: rtl/lmw_chk.sv
module lmw_chk #(
  parameter int unsigned AW     = 4,
  parameter int unsigned RD_LAT = 2,
  parameter int unsigned WR_LAT = 2,
  parameter int unsigned N_RD   = 1,
  parameter int unsigned N_WR   = 1,
  parameter int unsigned NR     = 2,
  parameter int unsigned NW     = 2
) (
  input logic             clk,
  input logic             wr_en0,
  input logic [AW-1:0]    wr_addr0,
  input logic             rw_en0,
  input logic             rw_wmode0,
  input logic [NW-1:0]    arr_we,
  input logic [NW*AW-1:0] arr_waddr,
  input logic [NR*AW-1:0] arr_raddr,
  input logic [NR-1:0]    rd_tail_ld
);
  localparam int unsigned LIM = RD_LAT + WR_LAT + 2;

  // Pipelines carry no reset: checks start once the bench has flushed them.
  int unsigned warm_cnt = 0;
  logic warm;
  always_ff @(posedge clk) if (warm_cnt < LIM) warm_cnt <= warm_cnt + 1;
  assign warm = (warm_cnt == LIM);

  // Independent history of the requests, WR_LAT-1 cycles deep.
  logic          d_wen, d_xw;
  logic [AW-1:0] d_waddr;
  generate
    if (WR_LAT == 1) begin : g_h0
      assign d_wen   = wr_en0;
      assign d_waddr = wr_addr0;
      assign d_xw    = rw_en0 & rw_wmode0;
    end else begin : g_hn
      logic          h_en [WR_LAT-1];
      logic          h_xw [WR_LAT-1];
      logic [AW-1:0] h_ad [WR_LAT-1];
      always_ff @(posedge clk) begin
        h_en[0] <= wr_en0;
        h_ad[0] <= wr_addr0;
        h_xw[0] <= rw_en0 && rw_wmode0;
        for (int k = 1; k < WR_LAT-1; k++) begin
          h_en[k] <= h_en[k-1];
          h_ad[k] <= h_ad[k-1];
          h_xw[k] <= h_xw[k-1];
        end
      end
      assign d_wen   = h_en[WR_LAT-2];
      assign d_waddr = h_ad[WR_LAT-2];
      assign d_xw    = h_xw[WR_LAT-2];
    end
  endgenerate

  // R3: a dedicated write reaches the array exactly WR_LAT-1 cycles after request
  p_wr_lat_r3: assert property (@(posedge clk) disable iff (!warm)
    arr_we[0] == d_wen);

  // R3: and carries the address of that request
  p_wr_addr_r3: assert property (@(posedge clk) disable iff (!warm)
    arr_we[0] |-> (arr_waddr[AW-1:0] == d_waddr));

  // R5: a combined port writes only for requests made in write mode
  p_rw_mode_r5: assert property (@(posedge clk) disable iff (!warm)
    arr_we[N_WR] == d_xw);

  // R2: the read address of a dedicated port holds when no request arrives
  p_raddr_hold_r2: assert property (@(posedge clk) disable iff (!warm)
    !rd_tail_ld[0] |=> $stable(arr_raddr[AW-1:0]));

  // R6: the combined port read address holds across writes and idle cycles
  p_rw_raddr_hold_r6: assert property (@(posedge clk) disable iff (!warm)
    !rd_tail_ld[N_RD] |=> $stable(arr_raddr[N_RD*AW +: AW]));
endmodule

bind lat_mem_wrap lmw_chk #(
  .AW(AW), .RD_LAT(RD_LAT), .WR_LAT(WR_LAT),
  .N_RD(N_RD), .N_WR(N_WR), .NR(NR), .NW(NW)
) u_lmw_chk (
  .clk(clk), .wr_en0(wr_en[0]), .wr_addr0(wr_addr[AW-1:0]),
  .rw_en0(rw_en[0]), .rw_wmode0(rw_wmode[0]),
  .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_raddr(arr_raddr),
  .rd_tail_ld(rd_tail_ld)
);

// File: tb/test_lat_mem_wrap.sv
module lmw_harness #(
  parameter int unsigned L = 2,
  parameter int unsigned W = 2
) (
  input logic clk
);
  typedef struct packed {
    logic [3:0]  tag;
    logic        re;  logic [3:0] ra;
    logic        we;  logic [3:0] wa; logic [15:0] wd; logic [1:0] wm;
    logic        xe;  logic xm; logic [3:0] xa; logic [15:0] xd; logic [1:0] xk;
  } vec_t;

  // tag, re,ra, we,wa,wd,wm, xe,xm,xa,xd,xk
  localparam vec_t TBL [16] = '{
    '{4'd1, 1'b1, 4'd1,  1'b1, 4'd2, 16'h1234, 2'b11, 1'b1, 1'b0, 4'd5,  16'h0000, 2'b00},
    '{4'd3, 1'b1, 4'd2,  1'b0, 4'd0, 16'h0000, 2'b00, 1'b1, 1'b1, 4'd6,  16'hBEEF, 2'b11},
    '{4'd3, 1'b1, 4'd2,  1'b0, 4'd0, 16'h0000, 2'b00, 1'b0, 1'b0, 4'd0,  16'h0000, 2'b00},
    '{4'd5, 1'b1, 4'd6,  1'b0, 4'd0, 16'h0000, 2'b00, 1'b1, 1'b0, 4'd6,  16'h0000, 2'b00},
    '{4'd4, 1'b1, 4'd7,  1'b1, 4'd7, 16'h5A5A, 2'b01, 1'b0, 1'b0, 4'd0,  16'h0000, 2'b00},
    '{4'd4, 1'b1, 4'd7,  1'b1, 4'd8, 16'hFFFF, 2'b10, 1'b1, 1'b0, 4'd8,  16'h0000, 2'b00},
    '{4'd4, 1'b1, 4'd8,  1'b1, 4'd9, 16'h0000, 2'b00, 1'b0, 1'b0, 4'd0,  16'h0000, 2'b00},
    '{4'd7, 1'b0, 4'd9,  1'b0, 4'd9, 16'hDEAD, 2'b11, 1'b0, 1'b1, 4'd9,  16'hDEAD, 2'b11},
    '{4'd7, 1'b1, 4'd9,  1'b0, 4'd0, 16'h0000, 2'b00, 1'b1, 1'b0, 4'd9,  16'h0000, 2'b00},
    '{4'd1, 1'b1, 4'd0,  1'b1, 4'd0, 16'h0F0F, 2'b11, 1'b1, 1'b1, 4'd15, 16'h4242, 2'b10},
    '{4'd5, 1'b1, 4'd0,  1'b0, 4'd0, 16'h0000, 2'b00, 1'b1, 1'b0, 4'd15, 16'h0000, 2'b00},
    '{4'd1, 1'b1, 4'd15, 1'b0, 4'd0, 16'h0000, 2'b00, 1'b1, 1'b0, 4'd0,  16'h0000, 2'b00},
    '{4'd3, 1'b0, 4'd0,  1'b1, 4'd4, 16'h7777, 2'b11, 1'b1, 1'b1, 4'd5,  16'h3333, 2'b01},
    '{4'd1, 1'b1, 4'd4,  1'b0, 4'd0, 16'h0000, 2'b00, 1'b1, 1'b0, 4'd5,  16'h0000, 2'b00},
    '{4'd5, 1'b1, 4'd5,  1'b0, 4'd0, 16'h0000, 2'b00, 1'b0, 1'b0, 4'd0,  16'h0000, 2'b00},
    '{4'd7, 1'b0, 4'd3,  1'b0, 4'd3, 16'hAAAA, 2'b11, 1'b0, 1'b0, 4'd3,  16'h0000, 2'b00}
  };

  logic        rd_en, wr_en, rw_en, rw_wmode;
  logic [3:0]  rd_addr, wr_addr, rw_addr;
  logic [15:0] rd_data, wr_data, rw_wdata, rw_rdata;
  logic [1:0]  wr_mask, rw_wmask;

  lat_mem_wrap #(
    .DEPTH(16), .DATA_W(16), .LANES(2), .RD_LAT(L), .WR_LAT(W),
    .N_RD(1), .N_WR(1), .N_RW(1)
  ) i_lat_mem_wrap (
    .clk(clk), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask),
    .rw_en(rw_en), .rw_wmode(rw_wmode), .rw_addr(rw_addr),
    .rw_wdata(rw_wdata), .rw_wmask(rw_wmask), .rw_rdata(rw_rdata)
  );

  int   n_chk = 0;
  int   n_bad = 0;
  logic done  = 1'b0;

  logic [15:0] mdl [16];
  vec_t        hist [64];
  int          c = 0;
  logic [3:0]  held_r, held_x;
  logic        vr = 1'b0, vx = 1'b0;

  function automatic string tag_s(input logic [3:0] t);
    case (t)
      4'd1: return "R1";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R1";
    endcase
  endfunction

  // Lane merge, written bit by bit: bit i belongs to lane i/8.
  function automatic logic [15:0] put(input logic [15:0] old, input logic [15:0] nw,
                                      input logic [1:0] mk);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = mk[i / 8] ? nw[i] : old[i];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s (L=%0d W=%0d cycle %0d): actual %h expected %h",
               tag, L, W, c, act, exp);
    end
  endtask

  task automatic step(input vec_t v);
    vec_t  h;
    string t;
    @(negedge clk);
    // writes requested W cycles ago are now visible (R3); dedicated before combined (R8)
    if (c >= int'(W)) begin
      h = hist[(c - int'(W)) % 64];
      if (h.we)          mdl[h.wa] = put(mdl[h.wa], h.wd, h.wm);
      if (h.xe && h.xm)  mdl[h.xa] = put(mdl[h.xa], h.xd, h.xk);
    end
    t = "R2";
    if (c >= int'(L)) begin
      h = hist[(c - int'(L)) % 64];
      if (h.re) begin
        held_r = h.ra; vr = 1'b1;
        t = (L == 1 || W == 1) ? "R9" : tag_s(h.tag);
      end
    end
    if (vr) chk(rd_data === mdl[held_r], t, rd_data, mdl[held_r]);
    t = "R6";
    if (c >= int'(L)) begin
      h = hist[(c - int'(L)) % 64];
      if (h.xe && !h.xm) begin held_x = h.xa; vx = 1'b1; t = "R5"; end
    end
    if (vx) chk(rw_rdata === mdl[held_x], t, rw_rdata, mdl[held_x]);
    rd_en = v.re; rd_addr = v.ra;
    wr_en = v.we; wr_addr = v.wa; wr_data = v.wd; wr_mask = v.wm;
    rw_en = v.xe; rw_wmode = v.xm; rw_addr = v.xa; rw_wdata = v.xd; rw_wmask = v.xk;
    hist[c % 64] = v;
    c++;
  endtask

  initial begin
    vec_t v;
    rd_en = 0; rd_addr = 0; wr_en = 0; wr_addr = 0; wr_data = 0; wr_mask = 0;
    rw_en = 0; rw_wmode = 0; rw_addr = 0; rw_wdata = 0; rw_wmask = 0;
    // Enables low while the reset-free pipelines fill.
    for (int i = 0; i < 8; i++) step('0);
    // Fill every word through the dedicated write port.
    for (int a = 0; a < 16; a++) begin
      v = '0; v.we = 1'b1; v.wa = 4'(a); v.wm = 2'b11;
      v.wd = 16'hA000 + 16'(a) * 16'h0111;
      step(v);
    end
    // Table walk, four passes with shifted addresses and data.
    for (int p = 0; p < 4; p++) begin
      for (int r = 0; r < 16; r++) begin
        v = TBL[r];
        v.ra ^= 4'(p); v.wa ^= 4'(p); v.xa ^= 4'(p);
        v.wd ^= 16'(p) * 16'h1111; v.xd ^= 16'(p) * 16'h2222;
        step(v);
      end
    end
    // R8: both write ports hit word 3 at the same edge; combined port wins.
    v = '0; v.we = 1'b1; v.wa = 4'd3; v.wd = 16'h1111; v.wm = 2'b11;
    v.xe = 1'b1; v.xm = 1'b1; v.xa = 4'd3; v.xd = 16'h2222; v.xk = 2'b11;
    step(v);
    // R8: only the low lane from the combined port; high lane from the dedicated port.
    v = '0; v.we = 1'b1; v.wa = 4'd10; v.wd = 16'h3344; v.wm = 2'b11;
    v.xe = 1'b1; v.xm = 1'b1; v.xa = 4'd10; v.xd = 16'h5566; v.xk = 2'b01;
    step(v);
    for (int i = 0; i < int'(W); i++) step('0);
    v = '0; v.tag = 4'd8; v.re = 1'b1; v.ra = 4'd3; v.xe = 1'b1; v.xa = 4'd10;
    step(v);
    v = '0; v.tag = 4'd8; v.re = 1'b1; v.ra = 4'd10;
    step(v);
    for (int i = 0; i < int'(L + W) + 3; i++) step('0);
    done = 1'b1;
  end
endmodule

module test_lat_mem_wrap;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  lmw_harness #(.L(2), .W(3)) h_a (.clk(clk));
  lmw_harness #(.L(1), .W(1)) h_b (.clk(clk));
  lmw_harness #(.L(3), .W(1)) h_c (.clk(clk));

  initial begin
    int total, bad;
    for (int cyc = 0; cyc < 5000; cyc++) begin
      if (h_a.done && h_b.done && h_c.done) break;
      @(posedge clk);
    end
    total = h_a.n_chk + h_b.n_chk + h_c.n_chk;
    bad   = h_a.n_bad + h_b.n_bad + h_c.n_bad;
    if (!(h_a.done && h_b.done && h_c.done)) begin
      total++; bad++;
      $display("FAIL R1 watchdog: done flags %b%b%b expected 111",
               h_a.done, h_b.done, h_c.done);
    end
    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end
endmodule